// File: doc/BRIEF.md
# Rotated-Byte Immediate Encoder and Expander

The block decides whether a 32-bit constant fits a 12-bit immediate format, in which an 8-bit unsigned byte is rotated right by twice a 4-bit rotate field. When the constant fits, the block gives back the 12-bit code word. Only even rotations from 0 to 30 can be expressed, so many constants that look small, such as 511 or 370, cannot be encoded. A code generator or an instruction builder uses the block to test a constant before choosing a one-instruction form.

The search is a small sequential engine. A start pulse captures the constant. The engine then tries one rotate value per clock cycle, beginning at zero, and stops at the first rotation that turns the constant into a plain byte. It raises a one-cycle done pulse together with a valid flag and the code word. A separate combinational expander turns any 12-bit code word back into its 32-bit value.

Top module: `rotimm_unit`

## Requirements
- R1: A synchronous reset, including one that arrives during a search, leaves busy, done and valid low and enc_out zero. No done pulse for the abandoned search appears afterwards.
- R2: enc_out[11:8] holds the rotate field r and enc_out[7:0] holds the byte n. The code word stands for n rotated right by 2*r bits. The expander maps dec_in to dec_out combinationally with the same rule.
- R3: valid is high with done exactly when the constant equals some byte rotated right by an even amount from 0 to 30. For example, 256, 384, 484, 16384, 255 and 0x06000000 are encodable, while 511, 370 and 0x06010000 are not.
- R4: When more than one encoding exists, the one with the smallest r is reported. For example, 256 gives 0xC01, 384 gives 0xD06, 484 gives 0xF79, 16384 gives 0x901, 0x06000000 gives 0x406 and 255 gives 0x0FF.
- R5: done is a single-cycle pulse. A start that is accepted at one rising edge causes done to follow r+1 edges later on success, or 16 edges later on failure, and never later than that.
- R6: On failure, valid is low and enc_out is zero while done is high.
- R7: A start pulse that arrives while busy is high is ignored. The search in progress continues on its original constant, and its result and timing do not change.
- R8: busy goes high on the edge that accepts a start. It stays high until the edge that raises done, and on that edge it goes low.
- R9: valid and enc_out keep their values after done until the next start is accepted. At that acceptance they clear to low and zero.
- R10: The constant 0 is encodable with code word 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search on value_in when idle |
| value_in | input | 32 | Constant to test |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| valid | output | 1 | Constant is encodable |
| enc_out | output | 12 | Code word {r, n}, zero on failure |
| dec_in | input | 12 | Code word to expand |
| dec_out | output | 32 | Expanded 32-bit value of dec_in |

## Verification
On every cycle, the assertions check the following properties. done is a single pulse that only ends a busy period. A failed result carries a zero code word. Every valid code word expands back to the captured constant. The captured constant stays fixed while a start arrives during busy. busy follows each accepted start, and the result holds between searches. The bench scenarios show the properties that need a reference. These are the minimum-rotation choice against an independent search, the exact edge count to done for each rotate value, the documented encodable and non-encodable constants, and the effect of a reset that aborts a search.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int ROT_W  = 4;
  localparam int ENC_W  = BYTE_W + ROT_W;
  localparam int N_ROT  = 1 << ROT_W;
  localparam int STEP   = WORD_W / N_ROT;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ROT_W-1:0]  rot_t;

  // Rotate field in the upper bits, byte in the lower bits.
  typedef struct packed {
    rot_t  rot;
    byte_t imm;
  } enc_t;

  function automatic word_t ror_word(word_t v, int unsigned amt);
    int unsigned a;
    a = amt % WORD_W;
    if (a == 0) return v;
    return (v >> a) | (v << (WORD_W - a));
  endfunction

  function automatic word_t rol_word(word_t v, int unsigned amt);
    int unsigned a;
    a = amt % WORD_W;
    if (a == 0) return v;
    return (v << a) | (v >> (WORD_W - a));
  endfunction

  function automatic word_t expand(enc_t e);
    return ror_word({{(WORD_W-BYTE_W){1'b0}}, e.imm}, STEP * int'(e.rot));
  endfunction
endpackage

// File: rtl/rotimm_decode.sv
module rotimm_decode
  import rotimm_pkg::*;
(
  input  enc_t  code,
  output word_t value
);
  always_comb value = expand(code);
endmodule

// File: rtl/rotimm_trial.sv
module rotimm_trial
  import rotimm_pkg::*;
(
  input  word_t value,
  input  rot_t  rot,
  output logic  hit,
  output byte_t imm
);
  word_t undone;

  // Undo the right rotation: the constant fits when what remains is a byte.
  always_comb begin
    undone = rol_word(value, STEP * int'(rot));
    hit    = (undone[WORD_W-1:BYTE_W] == '0);
    imm    = undone[BYTE_W-1:0];
  end
endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
  import rotimm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  word_t value,
  output logic  busy,
  output logic  done,
  output logic  valid,
  output enc_t  enc
);
  word_t val_q;
  rot_t  rot_q;
  logic  busy_q, done_q, valid_q;
  enc_t  enc_q;

  // Named internal events
  logic  accept;
  logic  probe_hit;
  byte_t probe_imm;
  logic  last_probe;
  logic  finish;

  rotimm_trial u_trial (
    .value (val_q),
    .rot   (rot_q),
    .hit   (probe_hit),
    .imm   (probe_imm)
  );

  assign accept     = start & ~busy_q;
  assign last_probe = (rot_q == rot_t'(N_ROT - 1));
  assign finish     = busy_q & (probe_hit | last_probe);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      rot_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      enc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        val_q   <= value;
        rot_q   <= '0;
        busy_q  <= 1'b1;
        valid_q <= 1'b0;
        enc_q   <= '0;
      end else if (busy_q) begin
        if (probe_hit) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
          enc_q   <= '{rot: rot_q, imm: probe_imm};
        end else if (last_probe) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          valid_q <= 1'b0;
          enc_q   <= '0;
        end else begin
          rot_q <= rot_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign valid = valid_q;
  assign enc   = enc_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));

  assert_fail_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (done_q && !valid_q) |-> (enc_q == '0));

  assert_roundtrip_R2: assert property (@(posedge clk) disable iff (rst)
    (done_q && valid_q) |-> (expand(enc_q) == val_q));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && !done_q));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> (val_q == $past(val_q)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!accept && !finish) |=> ($stable(enc_q) && $stable(valid_q)));
endmodule

// File: rtl/rotimm_unit.sv
module rotimm_unit
  import rotimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] value_in,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic [ENC_W-1:0]  enc_out,
  input  logic [ENC_W-1:0]  dec_in,
  output logic [WORD_W-1:0] dec_out
);
  enc_t  enc_s;
  enc_t  dec_code;
  word_t dec_val;

  rotimm_search u_search (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .value (value_in),
    .busy  (busy),
    .done  (done),
    .valid (valid),
    .enc   (enc_s)
  );

  assign dec_code = dec_in;

  rotimm_decode u_decode (
    .code  (dec_code),
    .value (dec_val)
  );

  assign enc_out = enc_s;
  assign dec_out = dec_val;
endmodule

// File: tb/tb_rotimm_unit.sv
module tb_rotimm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] value_in = '0;
  logic        busy, done, valid;
  logic [11:0] enc_out;
  logic [11:0] dec_in = '0;
  logic [31:0] dec_out;

  int checks = 0;
  int fails  = 0;

  rotimm_unit dut (
    .clk(clk), .rst(rst), .start(start), .value_in(value_in),
    .busy(busy), .done(done), .valid(valid), .enc_out(enc_out),
    .dec_in(dec_in), .dec_out(dec_out)
  );

  always #4 clk = ~clk;

  localparam int NV = 14;
  localparam logic [31:0] VALS [NV] = '{
    32'd256, 32'd384, 32'd484, 32'd16384, 32'h0600_0000, 32'd255, 32'd0,
    32'd511, 32'd370, 32'h0601_0000, 32'hFF00_0000, 32'hC000_003F,
    32'h0000_0104, 32'h8000_0001};
  // {valid, code word}
  localparam logic [12:0] EXPS [NV] = '{
    13'h1C01, 13'h1D06, 13'h1F79, 13'h1901, 13'h1406, 13'h10FF, 13'h1000,
    13'h0000, 13'h0000, 13'h0000, 13'h14FF, 13'h11FF,
    13'h1F41, 13'h1106};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent reference: double the word and slice a window.
  function automatic logic [12:0] ref_enc(logic [31:0] v);
    for (int r = 0; r < 16; r++) begin
      logic [63:0] d;
      logic [31:0] t;
      d = {v, v} << (2 * r);
      t = d[63:32];
      if (t < 32'd256) return {1'b1, 4'(r), t[7:0]};
    end
    return 13'h0;
  endfunction

  // Start a search; returns edges from acceptance to done.
  task automatic run(input logic [31:0] v, output int lat);
    @(negedge clk);
    value_in = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [12:0] e;
    logic [31:0] lcg;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !valid && enc_out == 0, "R1", "reset state",
        {busy, done, valid, enc_out}, 0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run(VALS[i], lat);
      e = ref_enc(VALS[i]);
      chk(e == EXPS[i], "R4", "reference vs table", {19'd0, e}, {19'd0, EXPS[i]});
      chk(valid == EXPS[i][12], "R3", "valid flag", {31'd0, valid}, {31'd0, EXPS[i][12]});
      chk(enc_out == EXPS[i][11:0], EXPS[i][12] ? "R4" : "R6", "code word",
          {20'd0, enc_out}, {20'd0, EXPS[i][11:0]});
      chk(lat == (EXPS[i][12] ? int'(EXPS[i][11:8]) + 1 : 16), "R5", "latency",
          lat, EXPS[i][12] ? int'(EXPS[i][11:8]) + 1 : 16);
      if (valid) begin
        dec_in = enc_out;
        #1;
        chk(dec_out == VALS[i], "R2", "expand round trip", dec_out, VALS[i]);
      end
      if (VALS[i] == 0)
        chk(valid && enc_out == 0, "R10", "zero encodes", {19'd0, valid, enc_out}, 32'h1000);
      @(negedge clk);
      chk(!done && !busy, "R5", "done single pulse", {busy, done}, 0);
      chk(valid == EXPS[i][12] && enc_out == EXPS[i][11:0], "R9", "result held",
          {19'd0, valid, enc_out}, {19'd0, EXPS[i]});
    end

    // Pseudo-random sweep of constructed and arbitrary constants
    lcg = 32'h1234_5678;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] v;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      v = (k % 2 == 0) ? ({24'd0, lcg[7:0]} << lcg[12:8]) : lcg;
      run(v, lat);
      e = ref_enc(v);
      chk({valid, enc_out} == e, "R4", "sweep encoding", {19'd0, valid, enc_out}, {19'd0, e});
      chk(lat == (e[12] ? int'(e[11:8]) + 1 : 16), "R5", "sweep latency", lat,
          e[12] ? int'(e[11:8]) + 1 : 16);
    end

    // Direct expander checks
    dec_in = 12'h4FF; #1;
    chk(dec_out == 32'hFF00_0000, "R2", "expand 0x4FF", dec_out, 32'hFF00_0000);
    dec_in = 12'hF79; #1;
    chk(dec_out == 32'd484, "R2", "expand 0xF79", dec_out, 32'd484);
    dec_in = 12'h1FF; #1;
    chk(dec_out == 32'hC000_003F, "R2", "expand 0x1FF", dec_out, 32'hC000_003F);

    // Start during busy is ignored; result cleared on acceptance
    @(negedge clk);
    value_in = 32'd511;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !valid && enc_out == 0, "R9", "clear on accept",
        {busy, valid, enc_out}, 32'h2000);
    chk(busy, "R8", "busy after accept", {31'd0, busy}, 1);
    lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    value_in = 32'd255;
    start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    chk(busy && !done, "R8", "busy mid-search", {busy, done}, 2'b10);
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == 16, "R7", "ignored start timing", lat, 16);
    chk(!valid && enc_out == 0, "R7", "ignored start result", {valid, enc_out}, 0);
    chk(!busy, "R8", "busy low with done", {31'd0, busy}, 0);

    // Reset during a search
    @(negedge clk);
    value_in = 32'h0601_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !valid && enc_out == 0, "R1", "reset aborts search",
        {busy, done, valid, enc_out}, 0);
    begin
      bit seen;
      seen = 0;
      repeat (20) begin @(negedge clk); if (done || busy) seen = 1; end
      chk(!seen, "R1", "no done after abort", {31'd0, seen}, 0);
    end

    // Engine usable after reset
    run(32'd16384, lat);
    chk(valid && enc_out == 12'h901 && lat == 10, "R3", "after reset",
        {19'd0, valid, enc_out}, 32'h1901);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule